// File: doc/BRIEF.md
# Serial Interface Register and Flag Core

This block is the byte-level control core of an asynchronous serial port. A host reaches it through an 8-bit register bus with eight byte offsets. It holds the frame mode, the bit-rate divisor, the control bits, one transmit data byte, the status flags, the receive data byte and two extension bytes. The mode and rate bytes are brought out to a separate frame timer. That timer reports the end of each transmitted frame with `frame_tick`. It also reports, with `rx_slot_tick`, that one frame time has passed since the last byte the core took in.

On the transmit side the core double-buffers one byte behind the byte on the line. A three-state machine tracks the two buffers:
- `TX_IDLE`: data-empty and transmit-end are both set.
- `TX_SENDING`: a byte is on the line and the buffer is free.
- `TX_QUEUED`: a byte is on the line and another waits in the buffer.

Its transitions are:
- Launch: `TX_IDLE` to `TX_SENDING`, on a data write.
- Queue: `TX_SENDING` to `TX_QUEUED`, on a data write.
- Overwrite: `TX_QUEUED` stays in `TX_QUEUED`, on a data write.
- Relaunch: `TX_QUEUED` to `TX_SENDING`, on a frame tick.
- Drain: `TX_SENDING` to `TX_IDLE`, on a frame tick.
- Idle tick: `TX_IDLE` stays in `TX_IDLE`, on a frame tick.
- Force: any state to `TX_IDLE`, on a control write that enables the transmitter.

Within one cycle the frame tick is applied before the data write. The receive side has a two-state machine:
- `RX_OPEN` accepts bytes.
- `RX_GAP` refuses them until the slot tick.

The transition Take goes from `RX_OPEN` to `RX_GAP` on an accepted byte. The transition Reopen goes from `RX_GAP` to `RX_OPEN` on `rx_slot_tick`. The receive side keeps one holding byte, an overrun flag and a framing flag, the latter set by a line break.

There are four interrupt lines. The receive and transmit lines are one-cycle pulses. The transmit-end and error lines are levels.

Top module: `sci_regcore`

## Requirements
- R1: After reset, reads at the offsets 0 to 7 return 0x00, 0xFF, 0x00, 0xFF, 0x84, 0x00, 0x00, 0x00, and all four interrupt lines are low.
- R2: The offsets are: 0 mode, 1 bit rate, 2 control, 3 transmit data, 4 status, 5 receive data, 6 and 7 extension bytes. The extension bytes read back what was written.
- R3: A write to offset 0 or 1 is ignored while control bit 5 (transmit enable) or control bit 4 (receive enable) is set.
- R4: The control bits are: bit 7 transmit interrupt enable, bit 6 receive/error interrupt enable, bit 2 transmit-end interrupt enable. A control write with bit 5 set sets status bit 7 (data empty) and status bit 2 (transmit end), and pulses `irq_tx` if the written bit 7 is set. A control write with bit 2 clear drops `irq_tend`. A control write with bit 6 clear drops `irq_err`.
- R5: A transmit data write while transmit-end is set launches the byte: `tx_strobe` pulses with `tx_byte` equal to it, transmit-end clears, data-empty stays set, `irq_tend` drops, and `irq_tx` pulses if enabled. Otherwise the byte waits and data-empty clears. A further write replaces the waiting byte.
- R6: On `frame_tick` a waiting byte is launched as in R5. With no byte waiting, transmit-end is set and `irq_tend` rises as a level if control bit 2 is set.
- R7: A byte taken while status bit 6 (receive full) is set is discarded. It sets status bit 5 (overrun) and raises `irq_err` if control bit 6 is set. Otherwise the byte is stored, receive-full sets, and `irq_rx` pulses if control bit 6 is set.
- R8: A read of offset 5 clears receive-full. A write to offset 5 changes nothing.
- R9: `rx_ready` is high only while receive enable is set and `rx_slot_tick` has come since the last byte taken. A byte offered while it is low is dropped without effect.
- R10: `brk_in` sets status bit 4 (framing error) and raises `irq_err` if control bit 6 is set.
- R11: A status write changes only bit 0 (multiprocessor transmit bit) and bits 5:3 (error bits). It drops `irq_err` when the last status read showed an error bit set and the written error field is zero.
- R12: Read data is valid in the cycle of the read strobe. Every other effect of a strobe appears on the outputs one clock after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Single-cycle register write strobe |
| bus_rd | input | 1 | Single-cycle register read strobe |
| bus_addr | input | 3 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| cfg_mode | output | 8 | Mode byte, to the frame timer |
| cfg_rate | output | 8 | Bit-rate byte, to the frame timer |
| frame_tick | input | 1 | End of the frame being transmitted |
| tx_strobe | output | 1 | One-cycle pulse: a byte leaves |
| tx_byte | output | 8 | Byte leaving, valid with `tx_strobe` |
| rx_valid | input | 1 | A received byte is offered |
| rx_byte | input | 8 | Offered received byte |
| rx_slot_tick | input | 1 | One frame time has passed since the last byte taken |
| rx_ready | output | 1 | The core will take an offered byte |
| brk_in | input | 1 | Line break detected |
| irq_rx | output | 1 | Receive interrupt pulse |
| irq_tx | output | 1 | Transmit interrupt pulse |
| irq_tend | output | 1 | Transmit-end interrupt level |
| irq_err | output | 1 | Error interrupt level |

## Verification
Register reads are combinational. The bench samples `bus_rdata` inside the read cycle, before the clock edge that applies the read's side effects. Strobes, pulses and flag changes caused by a write, tick or offered byte are registered once. The bench checks them 1 ns after the edge that takes the stimulus, so a pulse is seen in its only cycle. The bench also rechecks pulses a cycle later to confirm they have fallen. Queue depth is swept arithmetically: after n back-to-back data writes and enough ticks, the bench expects min(n,2) launches and the last byte written.

// File: rtl/sci_core_pkg.sv
`timescale 1ns/1ps
package sci_core_pkg;
    localparam int unsigned REG_AW = 3;

    localparam logic [REG_AW-1:0] OFS_MODE  = 3'd0;
    localparam logic [REG_AW-1:0] OFS_RATE  = 3'd1;
    localparam logic [REG_AW-1:0] OFS_CTRL  = 3'd2;
    localparam logic [REG_AW-1:0] OFS_TDATA = 3'd3;
    localparam logic [REG_AW-1:0] OFS_STAT  = 3'd4;
    localparam logic [REG_AW-1:0] OFS_RDATA = 3'd5;
    localparam logic [REG_AW-1:0] OFS_EXTA  = 3'd6;
    localparam logic [REG_AW-1:0] OFS_EXTB  = 3'd7;

    // control bit positions
    localparam int unsigned CB_TXIE = 7;
    localparam int unsigned CB_RXIE = 6;
    localparam int unsigned CB_TXEN = 5;
    localparam int unsigned CB_RXEN = 4;
    localparam int unsigned CB_ENDIE = 2;

    // status bit positions
    localparam int unsigned SB_EMPTY = 7;
    localparam int unsigned SB_FULL  = 6;
    localparam int unsigned SB_ERRHI = 5;
    localparam int unsigned SB_ERRLO = 3;
    localparam int unsigned SB_TEND  = 2;
    localparam int unsigned SB_MPBT  = 0;
    localparam int unsigned ERR_W    = SB_ERRHI - SB_ERRLO + 1;

    typedef enum logic [1:0] {
        TX_IDLE    = 2'd0,
        TX_SENDING = 2'd1,
        TX_QUEUED  = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_OPEN = 1'b0,
        RX_GAP  = 1'b1
    } rx_state_e;
endpackage

// File: rtl/sci_cfg_regs.sv
`timescale 1ns/1ps
module sci_cfg_regs
    import sci_core_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     mode_q,
    output logic [DW-1:0]     rate_q,
    output logic [DW-1:0]     ctrl_q,
    output logic [DW-1:0]     exta_q,
    output logic [DW-1:0]     extb_q
);
    localparam logic [DW-1:0] RATE_RST = {DW{1'b1}};

    logic locked;
    assign locked = ctrl_q[CB_TXEN] | ctrl_q[CB_RXEN];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            rate_q <= RATE_RST;
            ctrl_q <= '0;
            exta_q <= '0;
            extb_q <= '0;
        end else if (wr_en) begin
            unique case (addr)
                OFS_MODE: if (!locked) mode_q <= wdata;
                OFS_RATE: if (!locked) rate_q <= wdata;
                OFS_CTRL: ctrl_q <= wdata;
                OFS_EXTA: exta_q <= wdata;
                OFS_EXTB: extb_q <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sci_tx_ctrl.sv
`timescale 1ns/1ps
module sci_tx_ctrl
    import sci_core_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tdr_wr,
    input  logic          ctrl_wr,
    input  logic [DW-1:0] wdata,
    input  logic          frame_tick,
    input  logic          tie,
    input  logic          teie,
    output logic [DW-1:0] tdr_q,
    output logic          data_empty,
    output logic          tx_end,
    output logic          tx_strobe,
    output logic [DW-1:0] tx_byte,
    output logic          irq_tx,
    output logic          irq_tend
);
    localparam logic [DW-1:0] TDR_RST = {DW{1'b1}};

    tx_state_e st_q, st_mid, st_n;
    logic          launch;
    logic          tend_set;
    logic [DW-1:0] launch_byte;
    logic [DW-1:0] tdr_n;
    logic          irq_tx_n;
    logic          irq_tend_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TX_IDLE;
            tdr_q <= TDR_RST;
        end else begin
            st_q  <= st_n;
            tdr_q <= tdr_n;
        end
    end

    // next state: tick first, then data write, then a forcing control write
    always_comb begin
        st_mid      = st_q;
        launch      = 1'b0;
        tend_set    = 1'b0;
        launch_byte = tdr_q;
        tdr_n       = tdr_q;
        if (frame_tick) begin
            unique case (st_q)
                TX_QUEUED:  begin launch = 1'b1; st_mid = TX_SENDING; end
                TX_SENDING: begin st_mid = TX_IDLE; tend_set = teie; end
                TX_IDLE:    tend_set = teie;
                default:    st_mid = TX_IDLE;
            endcase
        end
        st_n = st_mid;
        if (tdr_wr) begin
            tdr_n = wdata;
            unique case (st_mid)
                TX_IDLE: begin
                    launch      = 1'b1;
                    launch_byte = wdata;
                    st_n        = TX_SENDING;
                end
                TX_SENDING: st_n = TX_QUEUED;
                TX_QUEUED:  st_n = TX_QUEUED;
                default:    st_n = TX_IDLE;
            endcase
        end
        if (ctrl_wr && wdata[CB_TXEN]) begin
            st_n = TX_IDLE;
        end
    end

    // interrupt and strobe next values
    always_comb begin
        irq_tx_n = (launch & tie) |
                   (ctrl_wr & wdata[CB_TXEN] & wdata[CB_TXIE]);
        if (launch) begin
            irq_tend_n = 1'b0;
        end else if (ctrl_wr && !wdata[CB_ENDIE]) begin
            irq_tend_n = 1'b0;
        end else if (tend_set) begin
            irq_tend_n = 1'b1;
        end else begin
            irq_tend_n = irq_tend;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_strobe <= 1'b0;
            tx_byte   <= '0;
            irq_tx    <= 1'b0;
            irq_tend  <= 1'b0;
        end else begin
            tx_strobe <= launch;
            if (launch) tx_byte <= launch_byte;
            irq_tx    <= irq_tx_n;
            irq_tend  <= irq_tend_n;
        end
    end

    assign data_empty = (st_q != TX_QUEUED);
    assign tx_end     = (st_q == TX_IDLE);
endmodule

// File: rtl/sci_rx_ctrl.sv
`timescale 1ns/1ps
module sci_rx_ctrl
    import sci_core_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [DW-1:0]    rx_byte,
    input  logic             rx_slot_tick,
    input  logic             brk,
    input  logic             re,
    input  logic             rie,
    input  logic             ctrl_wr,
    input  logic             stat_wr,
    input  logic             stat_rd,
    input  logic             rdr_rd,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdr_q,
    output logic             rx_full,
    output logic [ERR_W-1:0] err_q,
    output logic             mpbt_q,
    output logic             rx_ready,
    output logic             irq_rx,
    output logic             irq_err
);
    rx_state_e st_q, st_n;
    logic             take;
    logic             full_mid;
    logic             accept;
    logic             overrun;
    logic [ERR_W-1:0] snap_q;
    logic [ERR_W-1:0] err_base;
    logic [ERR_W-1:0] err_n;
    logic             err_set;
    logic             ctrl_clr;
    logic             stat_clr;
    logic             irq_err_n;

    assign rx_ready = re & (st_q == RX_OPEN);
    assign take     = rx_valid & rx_ready;
    assign full_mid = rx_full & ~rdr_rd;
    assign accept   = take & ~full_mid;
    assign overrun  = take & full_mid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_OPEN;
        else        st_q <= st_n;
    end

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            RX_OPEN: if (take)         st_n = RX_GAP;
            RX_GAP:  if (rx_slot_tick) st_n = RX_OPEN;
            default: st_n = RX_OPEN;
        endcase
    end

    always_comb begin
        err_base  = stat_wr ? wdata[SB_ERRHI:SB_ERRLO] : err_q;
        err_n     = err_base | {overrun, brk, 1'b0};
        err_set   = (overrun | brk) & rie;
        ctrl_clr  = ctrl_wr & ~wdata[CB_RXIE];
        stat_clr  = stat_wr & (snap_q != '0) &
                    (wdata[SB_ERRHI:SB_ERRLO] == '0);
        if (ctrl_clr)      irq_err_n = 1'b0;
        else if (err_set)  irq_err_n = 1'b1;
        else if (stat_clr) irq_err_n = 1'b0;
        else               irq_err_n = irq_err;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdr_q   <= '0;
            rx_full <= 1'b0;
            err_q   <= '0;
            mpbt_q  <= 1'b0;
            snap_q  <= '0;
            irq_rx  <= 1'b0;
            irq_err <= 1'b0;
        end else begin
            if (accept) rdr_q <= rx_byte;
            rx_full <= full_mid | accept;
            err_q   <= err_n;
            if (stat_wr) mpbt_q <= wdata[SB_MPBT];
            if (stat_rd) snap_q <= err_q;
            irq_rx  <= accept & rie;
            irq_err <= irq_err_n;
        end
    end
endmodule

// File: rtl/sci_regcore.sv
`timescale 1ns/1ps
module sci_regcore
    import sci_core_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [DW-1:0]     cfg_mode,
    output logic [DW-1:0]     cfg_rate,
    input  logic              frame_tick,
    output logic              tx_strobe,
    output logic [DW-1:0]     tx_byte,
    input  logic              rx_valid,
    input  logic [DW-1:0]     rx_byte,
    input  logic              rx_slot_tick,
    output logic              rx_ready,
    input  logic              brk_in,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_tend,
    output logic              irq_err
);
    logic [DW-1:0]    ctrl_q;
    logic [DW-1:0]    exta_q;
    logic [DW-1:0]    extb_q;
    logic [DW-1:0]    tdr_q;
    logic [DW-1:0]    rdr_q;
    logic [DW-1:0]    stat_v;
    logic [ERR_W-1:0] err_q;
    logic             data_empty;
    logic             tx_end;
    logic             rx_full;
    logic             mpbt_q;
    logic             wr_ctrl;
    logic             wr_tdata;
    logic             wr_stat;
    logic             rd_stat;
    logic             rd_rdata;

    assign wr_ctrl  = bus_wr & (bus_addr == OFS_CTRL);
    assign wr_tdata = bus_wr & (bus_addr == OFS_TDATA);
    assign wr_stat  = bus_wr & (bus_addr == OFS_STAT);
    assign rd_stat  = bus_rd & (bus_addr == OFS_STAT);
    assign rd_rdata = bus_rd & (bus_addr == OFS_RDATA);

    sci_cfg_regs #(.DW(DW)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .mode_q (cfg_mode),
        .rate_q (cfg_rate),
        .ctrl_q (ctrl_q),
        .exta_q (exta_q),
        .extb_q (extb_q)
    );

    sci_tx_ctrl #(.DW(DW)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tdr_wr     (wr_tdata),
        .ctrl_wr    (wr_ctrl),
        .wdata      (bus_wdata),
        .frame_tick (frame_tick),
        .tie        (ctrl_q[CB_TXIE]),
        .teie       (ctrl_q[CB_ENDIE]),
        .tdr_q      (tdr_q),
        .data_empty (data_empty),
        .tx_end     (tx_end),
        .tx_strobe  (tx_strobe),
        .tx_byte    (tx_byte),
        .irq_tx     (irq_tx),
        .irq_tend   (irq_tend)
    );

    sci_rx_ctrl #(.DW(DW)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_byte      (rx_byte),
        .rx_slot_tick (rx_slot_tick),
        .brk          (brk_in),
        .re           (ctrl_q[CB_RXEN]),
        .rie          (ctrl_q[CB_RXIE]),
        .ctrl_wr      (wr_ctrl),
        .stat_wr      (wr_stat),
        .stat_rd      (rd_stat),
        .rdr_rd       (rd_rdata),
        .wdata        (bus_wdata),
        .rdr_q        (rdr_q),
        .rx_full      (rx_full),
        .err_q        (err_q),
        .mpbt_q       (mpbt_q),
        .rx_ready     (rx_ready),
        .irq_rx       (irq_rx),
        .irq_err      (irq_err)
    );

    always_comb begin
        stat_v                   = '0;
        stat_v[SB_EMPTY]         = data_empty;
        stat_v[SB_FULL]          = rx_full;
        stat_v[SB_ERRHI:SB_ERRLO] = err_q;
        stat_v[SB_TEND]          = tx_end;
        stat_v[SB_MPBT]          = mpbt_q;
    end

    always_comb begin
        unique case (bus_addr)
            OFS_MODE:  bus_rdata = cfg_mode;
            OFS_RATE:  bus_rdata = cfg_rate;
            OFS_CTRL:  bus_rdata = ctrl_q;
            OFS_TDATA: bus_rdata = tdr_q;
            OFS_STAT:  bus_rdata = stat_v;
            OFS_RDATA: bus_rdata = rdr_q;
            OFS_EXTA:  bus_rdata = exta_q;
            OFS_EXTB:  bus_rdata = extb_q;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sci_regcore_chk.sv
`timescale 1ns/1ps
module sci_regcore_chk
    import sci_core_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] ctrl_q,
    input logic [DW-1:0] cfg_mode,
    input logic [DW-1:0] cfg_rate,
    input logic          tx_strobe,
    input logic          tx_end,
    input logic          rx_full,
    input logic          rx_ready,
    input logic          irq_rx,
    input logic          irq_tend,
    input logic          irq_err
);
    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CB_TXEN] | ctrl_q[CB_RXEN]) |=> $stable(cfg_mode)); // R3
    AST_RATE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CB_TXEN] | ctrl_q[CB_RXEN]) |=> $stable(cfg_rate)); // R3
    AST_LAUNCH_DROPS_TEND: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> (!irq_tend && !tx_end)); // R5
    AST_TEND_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tend |-> ctrl_q[CB_ENDIE]); // R6
    AST_RXPULSE_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> rx_full); // R7
    AST_ERR_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> ctrl_q[CB_RXIE]); // R4
    AST_READY_NEEDS_RE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> ctrl_q[CB_RXEN]); // R9
endmodule

bind sci_regcore sci_regcore_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_q    (ctrl_q),
    .cfg_mode  (cfg_mode),
    .cfg_rate  (cfg_rate),
    .tx_strobe (tx_strobe),
    .tx_end    (tx_end),
    .rx_full   (rx_full),
    .rx_ready  (rx_ready),
    .irq_rx    (irq_rx),
    .irq_tend  (irq_tend),
    .irq_err   (irq_err)
);

// File: tb/sim_sci_regcore.sv
`timescale 1ns/1ps
module sim_sci_regcore;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, cfg_mode, cfg_rate, tx_byte;
    logic       frame_tick = 1'b0, tx_strobe;
    logic       rx_valid = 1'b0, rx_slot_tick = 1'b0, brk_in = 1'b0, rx_ready;
    logic [7:0] rx_byte = '0;
    logic       irq_rx, irq_tx, irq_tend, irq_err;

    int checks = 0;
    int errors = 0;
    int strobe_cnt = 0;
    logic [7:0] last_tx = '0;
    logic       done = 1'b0;

    always #2.5 clk = ~clk;

    sci_regcore u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_mode(cfg_mode), .cfg_rate(cfg_rate), .frame_tick(frame_tick),
        .tx_strobe(tx_strobe), .tx_byte(tx_byte), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_slot_tick(rx_slot_tick), .rx_ready(rx_ready),
        .brk_in(brk_in), .irq_rx(irq_rx), .irq_tx(irq_tx),
        .irq_tend(irq_tend), .irq_err(irq_err)
    );

    always @(posedge clk) begin
        if (tx_strobe) begin
            strobe_cnt <= strobe_cnt + 1;
            last_tx    <= tx_byte;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic rdchk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic tick();
        @(negedge clk); frame_tick = 1'b1;
        @(posedge clk); #1; frame_tick = 1'b0;
    endtask

    task automatic slot();
        @(negedge clk); rx_slot_tick = 1'b1;
        @(posedge clk); #1; rx_slot_tick = 1'b0;
    endtask

    task automatic offer(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(posedge clk); #1; rx_valid = 1'b0;
    endtask

    task automatic brk();
        @(negedge clk); brk_in = 1'b1;
        @(posedge clk); #1; brk_in = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] exp_mode, exp_rate;
        int base;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 / R12: reset values, read in the strobe cycle
        rdchk("R1 mode", 3'd0, 8'h00);
        rdchk("R1 rate", 3'd1, 8'hFF);
        rdchk("R1 ctrl", 3'd2, 8'h00);
        rdchk("R1 tdata", 3'd3, 8'hFF);
        rdchk("R12 R1 status", 3'd4, 8'h84);
        rdchk("R1 rdata", 3'd5, 8'h00);
        rdchk("R1 exta", 3'd6, 8'h00);
        rdchk("R1 extb", 3'd7, 8'h00);
        check("R1 irqs", {4'd0, irq_rx, irq_tx, irq_tend, irq_err}, 8'h00);

        // R2: extension bytes
        wr(3'd6, 8'h3C); wr(3'd7, 8'hC3);
        rdchk("R2 exta", 3'd6, 8'h3C);
        rdchk("R2 extb", 3'd7, 8'hC3);

        // R3: lock sweep over the four enable combinations
        exp_mode = 8'h00; exp_rate = 8'hFF;
        for (int k = 0; k < 4; k++) begin
            wr(3'd2, 8'(k << 4));
            wr(3'd0, 8'(8'h10 + k));
            wr(3'd1, 8'(8'h20 + k));
            if (k == 0) begin
                exp_mode = 8'(8'h10 + k); exp_rate = 8'(8'h20 + k);
            end
            rdchk("R3 mode", 3'd0, exp_mode);
            rdchk("R3 rate", 3'd1, exp_rate);
        end
        wr(3'd2, 8'h00);

        // R4 control write with TE and TIE
        wr(3'd2, 8'hA4);
        check("R4 irq_tx pulse", {7'd0, irq_tx}, 8'h01);
        rdchk("R4 status", 3'd4, 8'h84);
        wr(3'd2, 8'h84);
        check("R4 no pulse without TE", {7'd0, irq_tx}, 8'h00);
        wr(3'd2, 8'hA4);

        // R5 immediate launch
        wr(3'd3, 8'h11);
        check("R5 strobe", {7'd0, tx_strobe}, 8'h01);
        check("R5 byte", tx_byte, 8'h11);
        check("R5 irq_tx", {7'd0, irq_tx}, 8'h01);
        rdchk("R5 status sending", 3'd4, 8'h80);
        wr(3'd3, 8'h22);
        check("R5 no strobe", {7'd0, tx_strobe}, 8'h00);
        rdchk("R5 status queued", 3'd4, 8'h00);
        wr(3'd3, 8'h33);
        rdchk("R5 overwrite", 3'd3, 8'h33);

        // R6 frame ticks
        tick();
        check("R6 relaunch strobe", {7'd0, tx_strobe}, 8'h01);
        check("R6 relaunch byte", tx_byte, 8'h33);
        check("R6 irq_tx", {7'd0, irq_tx}, 8'h01);
        check("R6 no tend yet", {7'd0, irq_tend}, 8'h00);
        rdchk("R6 status sending", 3'd4, 8'h80);
        tick();
        check("R6 irq_tend level", {7'd0, irq_tend}, 8'h01);
        rdchk("R6 status idle", 3'd4, 8'h84);
        check("R6 tend held", {7'd0, irq_tend}, 8'h01);
        wr(3'd3, 8'h44);
        check("R5 tend dropped on launch", {7'd0, irq_tend}, 8'h00);
        tick();
        check("R6 tend again", {7'd0, irq_tend}, 8'h01);
        wr(3'd2, 8'hA0);
        check("R4 tend dropped by TEIE clear", {7'd0, irq_tend}, 8'h00);

        // R5/R6 queue sweep
        for (int n = 1; n <= 3; n++) begin
            wr(3'd2, 8'h20);
            base = strobe_cnt;
            for (int i = 0; i < n; i++) wr(3'd3, 8'(8'h40 + i));
            tick(); tick(); tick();
            @(negedge clk);
            check("R6 sweep count", 8'(strobe_cnt - base), 8'((n < 2) ? n : 2));
            check("R5 sweep last byte", last_tx, 8'(8'h40 + n - 1));
            rdchk("R6 sweep status", 3'd4, 8'h84);
        end

        // R7 / R9 receive
        wr(3'd2, 8'h50);
        check("R9 ready", {7'd0, rx_ready}, 8'h01);
        offer(8'hA5);
        check("R7 irq_rx", {7'd0, irq_rx}, 8'h01);
        check("R9 gap", {7'd0, rx_ready}, 8'h00);
        rdchk("R7 status full", 3'd4, 8'hC4);
        offer(8'h5A);
        rdchk("R9 dropped in gap", 3'd4, 8'hC4);
        check("R9 no err", {7'd0, irq_err}, 8'h00);
        slot();
        check("R9 reopened", {7'd0, rx_ready}, 8'h01);
        offer(8'h5A);
        check("R7 overrun irq", {7'd0, irq_err}, 8'h01);
        check("R7 no rx pulse", {7'd0, irq_rx}, 8'h00);
        rdchk("R7 status overrun", 3'd4, 8'hE4);
        rdchk("R7 R8 kept byte", 3'd5, 8'hA5);
        rdchk("R8 full cleared", 3'd4, 8'hA4);
        wr(3'd4, 8'h00);
        check("R11 err cleared", {7'd0, irq_err}, 8'h00);
        rdchk("R11 status", 3'd4, 8'h84);

        // R10 break and R11 write without a showing read
        brk();
        check("R10 irq_err", {7'd0, irq_err}, 8'h01);
        wr(3'd4, 8'h00);
        check("R11 irq kept", {7'd0, irq_err}, 8'h01);
        rdchk("R11 bits cleared", 3'd4, 8'h84);
        wr(3'd2, 8'h10);
        check("R4 err dropped by RIE clear", {7'd0, irq_err}, 8'h00);
        brk();
        check("R10 no irq", {7'd0, irq_err}, 8'h00);
        rdchk("R10 fer", 3'd4, 8'h94);
        wr(3'd4, 8'h00);

        // R8 receive data write ignored
        slot();
        offer(8'h77);
        check("R7 no pulse w/o RIE", {7'd0, irq_rx}, 8'h00);
        wr(3'd5, 8'h00);
        rdchk("R8 write ignored", 3'd4, 8'hC4);
        rdchk("R8 data", 3'd5, 8'h77);
        rdchk("R8 cleared", 3'd4, 8'h84);

        // R9 receive disabled
        wr(3'd2, 8'h00);
        slot();
        check("R9 not ready", {7'd0, rx_ready}, 8'h00);
        offer(8'h99);
        rdchk("R9 ignored status", 3'd4, 8'h84);
        rdchk("R9 ignored data", 3'd5, 8'h77);

        // R11 writable fields only
        wr(3'd4, 8'h01);
        rdchk("R11 mpbt", 3'd4, 8'h85);
        wr(3'd4, 8'hC1);
        rdchk("R11 top bits ignored", 3'd4, 8'h85);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule